// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block holds the steering logic of a five-stage integer pipeline. It compares the two source register numbers of the instruction now in the execute stage with the destination registers of the two older instructions still in flight. From that comparison it picks, for each ALU operand, the register file, the result one stage ahead, or the result two stages ahead. It also looks at the instruction being decoded. When that instruction needs a value that a load in execute has not yet fetched, the block freezes the front of the pipeline for one cycle and turns the decoded instruction into a bubble.

An exception flag raised in the execute stage makes the block clear the three youngest instructions in fetch, decode and execute. The block does not hold the program counter during that flush, so the redirect to the handler can proceed. The surrounding pipeline feeds the block its pipeline-register fields and acts on the strobes it returns. The datapath muxes, the register file and the handler vectoring are outside the block.

Top module: `hzfwd_top`

## Requirements
- R1: With no matching older writer, each operand select is 2'b00, meaning the operand comes from the register file.
- R2: When the instruction one ahead has its write flag set, a nonzero destination, and a destination equal to an operand's source, that operand's select is 2'b01.
- R3: When only the instruction two ahead qualifies by the same test, that operand's select is 2'b10.
- R4: When both older instructions write the operand's source register, the nearer one wins and the select is 2'b01. Each operand is decided on its own.
- R5: An older instruction whose write flag is low, or whose destination is register 0, never causes forwarding.
- R6: A load in execute whose destination equals either decode-stage source causes a stall. The stall drives pcWrite and ifIdWrite low and idFlush high, and keeps ifFlush and exFlush low.
- R7: With no hazard and no exception, pcWrite and ifIdWrite are 1 and all three flush strobes are 0. This includes the case where the execute-stage instruction is not a load, even if its destination matches.
- R8: An exception flag raises ifFlush, idFlush and exFlush together and leaves pcWrite and ifIdWrite at 1.
- R9: When an exception and a load-use hazard occur in the same cycle, the exception response of R8 is produced and no stall is inserted.
- R10: A stall never lasts two consecutive cycles. If the load-use pattern is still present in the cycle after a stall, that cycle is not stalled. It may stall again one cycle later.
- R11: After reset, with all inputs zero, both selects are 2'b00, pcWrite and ifIdWrite are 1, and the flush strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idExRs1 | input | 5 | First source register of the execute-stage instruction |
| idExRs2 | input | 5 | Second source register of the execute-stage instruction |
| exMemRd | input | 5 | Destination of the instruction one stage ahead |
| exMemRegWrite | input | 1 | Write flag of the instruction one stage ahead |
| memWbRd | input | 5 | Destination of the instruction two stages ahead |
| memWbRegWrite | input | 1 | Write flag of the instruction two stages ahead |
| ifIdRs1 | input | 5 | First source register of the decode-stage instruction |
| ifIdRs2 | input | 5 | Second source register of the decode-stage instruction |
| idExRd | input | 5 | Destination of the execute-stage instruction |
| idExMemRead | input | 1 | Execute-stage instruction is a load |
| exExcept | input | 1 | Exception detected in execute |
| fwdA | output | 2 | Select for the first ALU operand |
| fwdB | output | 2 | Select for the second ALU operand |
| pcWrite | output | 1 | Program counter update enable |
| ifIdWrite | output | 1 | Fetch/decode register write enable |
| ifFlush | output | 1 | Clear the fetch/decode register |
| idFlush | output | 1 | Zero the control bits leaving decode |
| exFlush | output | 1 | Zero the control bits leaving execute |

## Verification
The forwarding logic is driven with several source and destination patterns. One has a single near writer, which shows that the 01 path works. One has a single far writer, which shows that the 10 path works. One has both writers hitting the same register, which confirms the near writer wins. One has each operand fed from a different stage, which shows the two selects are decided independently. Patterns with the write flag low or destination 0 separate a true match from a stale or hard-wired-zero match.

On the control side, a load matching the first source and a load matching the second source each prove that both comparisons are live. A matching non-load shows that the load flag gates the stall. Holding the hazard for three cycles shows the stall alternates and never repeats back to back. A combined exception and hazard shows which response wins.

// File: rtl/hzfwd_pkg.sv
package hzfwd_pkg;

  typedef logic [1:0] fwdSel_t;

  localparam fwdSel_t FWD_REGFILE = 2'b00;
  localparam fwdSel_t FWD_EXMEM   = 2'b01;
  localparam fwdSel_t FWD_MEMWB   = 2'b10;

  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic ifFlush;
    logic idFlush;
    logic exFlush;
  } pipeStrobes_t;

endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hzfwd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   srcReg,
  input  logic [REG_W-1:0]                exMemRd,
  input  logic                            exMemRegWrite,
  input  logic [REG_W-1:0]                memWbRd,
  input  logic                            memWbRegWrite,
  output fwdSel_t [NUM_SRC-1:0]           sel
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exMemLive;
  logic memWbLive;

  // A writer only counts when it really writes, and never for register 0.
  assign exMemLive = exMemRegWrite && (exMemRd != ZERO_REG);
  assign memWbLive = memWbRegWrite && (memWbRd != ZERO_REG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hitNear;
    logic hitFar;

    assign hitNear = exMemLive && (exMemRd == srcReg[i]);
    assign hitFar  = memWbLive && (memWbRd == srcReg[i]);

    // The nearer producer holds the newer value, so it is tested first.
    assign sel[i] = hitNear ? FWD_EXMEM :
                    hitFar  ? FWD_MEMWB : FWD_REGFILE;

    // R4, R2: a qualifying near writer always wins.
    p_near_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exMemRegWrite && (exMemRd != ZERO_REG) && (exMemRd == srcReg[i]))
        |-> (sel[i] == FWD_EXMEM));

    // R3: a far select needs a live far writer on this register.
    p_far_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[i] == FWD_MEMWB) |-> (memWbRegWrite && (memWbRd == srcReg[i])));

    // R5: register 0 is never forwarded.
    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (srcReg[i] == ZERO_REG) |-> (sel[i] == FWD_REGFILE));

    // R5: with no writer active, the register file is selected.
    p_no_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!exMemRegWrite && !memWbRegWrite) |-> (sel[i] == FWD_REGFILE));
  end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzfwd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0][REG_W-1:0]  ifIdSrc,
  input  logic [REG_W-1:0]               idExRd,
  input  logic                           idExMemRead,
  input  logic                           exExcept,
  output pipeStrobes_t                   strobes
);

  logic [NUM_SRC-1:0] srcHit;
  logic               loadUse;
  logic               bubbleQ;
  logic               stallNow;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign srcHit[i] = (idExRd == ifIdSrc[i]);
  end

  assign loadUse = idExMemRead && (|srcHit);

  // The exception overrides the stall. A bubble inserted last cycle
  // blocks a second one in a row.
  assign stallNow = loadUse && !exExcept && !bubbleQ;

  always_ff @(posedge clk) begin
    if (!rst_n) bubbleQ <= 1'b0;
    else        bubbleQ <= stallNow;
  end

  always_comb begin
    strobes.pcWrite   = !stallNow;
    strobes.ifIdWrite = !stallNow;
    strobes.ifFlush   = exExcept;
    strobes.idFlush   = exExcept || stallNow;
    strobes.exFlush   = exExcept;
  end

  // R6: a hold comes with exactly this strobe set.
  p_stall_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.pcWrite |-> (!strobes.ifIdWrite && strobes.idFlush &&
                          !strobes.ifFlush && !strobes.exFlush));

  // R7: with no load and no exception, the pipeline runs clean.
  p_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idExMemRead && !exExcept) |-> (strobes.pcWrite && strobes.ifIdWrite &&
      !strobes.ifFlush && !strobes.idFlush && !strobes.exFlush));

  // R8: an exception flushes all three young stages.
  p_exc_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exExcept |-> (strobes.ifFlush && strobes.idFlush && strobes.exFlush));

  // R9: an exception never holds the PC or the decode register.
  p_exc_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exExcept |-> (strobes.pcWrite && strobes.ifIdWrite));

  // R10: two holds never come back to back.
  p_single_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.pcWrite |=> strobes.pcWrite);

endmodule

// File: rtl/hzfwd_top.sv
module hzfwd_top
  import hzfwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] idExRs1,
  input  logic [REG_W-1:0] idExRs2,
  input  logic [REG_W-1:0] exMemRd,
  input  logic             exMemRegWrite,
  input  logic [REG_W-1:0] memWbRd,
  input  logic             memWbRegWrite,
  input  logic [REG_W-1:0] ifIdRs1,
  input  logic [REG_W-1:0] ifIdRs2,
  input  logic [REG_W-1:0] idExRd,
  input  logic             idExMemRead,
  input  logic             exExcept,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             ifFlush,
  output logic             idFlush,
  output logic             exFlush
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] exSrc;
  logic [NUM_SRC-1:0][REG_W-1:0] idSrc;
  fwdSel_t [NUM_SRC-1:0]         selVec;
  pipeStrobes_t                  strobes;

  assign exSrc = {idExRs2, idExRs1};
  assign idSrc = {ifIdRs2, ifIdRs1};

  fwd_select #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_fwd (
    .clk           (clk),
    .rst_n         (rst_n),
    .srcReg        (exSrc),
    .exMemRd       (exMemRd),
    .exMemRegWrite (exMemRegWrite),
    .memWbRd       (memWbRd),
    .memWbRegWrite (memWbRegWrite),
    .sel           (selVec)
  );

  hazard_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_haz (
    .clk         (clk),
    .rst_n       (rst_n),
    .ifIdSrc     (idSrc),
    .idExRd      (idExRd),
    .idExMemRead (idExMemRead),
    .exExcept    (exExcept),
    .strobes     (strobes)
  );

  assign fwdA      = selVec[0];
  assign fwdB      = selVec[1];
  assign pcWrite   = strobes.pcWrite;
  assign ifIdWrite = strobes.ifIdWrite;
  assign ifFlush   = strobes.ifFlush;
  assign idFlush   = strobes.idFlush;
  assign exFlush   = strobes.exFlush;

endmodule

// File: tb/sim_hzfwd_top.sv
module sim_hzfwd_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] idExRs1, idExRs2, exMemRd, memWbRd, ifIdRs1, ifIdRs2, idExRd;
  logic       exMemRegWrite, memWbRegWrite, idExMemRead, exExcept;
  logic [1:0] fwdA, fwdB;
  logic       pcWrite, ifIdWrite, ifFlush, idFlush, exFlush;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Control strobes packed as {pcWrite, ifIdWrite, ifFlush, idFlush, exFlush}.
  localparam logic [4:0] RUN   = 5'b11000;
  localparam logic [4:0] HOLD  = 5'b00010;
  localparam logic [4:0] FLUSH = 5'b11111;

  always #5 clk = ~clk;

  hzfwd_top u0 (
    .clk(clk), .rst_n(rst_n),
    .idExRs1(idExRs1), .idExRs2(idExRs2),
    .exMemRd(exMemRd), .exMemRegWrite(exMemRegWrite),
    .memWbRd(memWbRd), .memWbRegWrite(memWbRegWrite),
    .ifIdRs1(ifIdRs1), .ifIdRs2(ifIdRs2),
    .idExRd(idExRd), .idExMemRead(idExMemRead), .exExcept(exExcept),
    .fwdA(fwdA), .fwdB(fwdB),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite),
    .ifFlush(ifFlush), .idFlush(idFlush), .exFlush(exFlush)
  );

  task automatic chk(input string req, input string what,
                     input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ctl();
    return {pcWrite, ifIdWrite, ifFlush, idFlush, exFlush};
  endfunction

  task automatic clearIn();
    idExRs1 = 0; idExRs2 = 0; exMemRd = 0; memWbRd = 0;
    ifIdRs1 = 0; ifIdRs2 = 0; idExRd = 0;
    exMemRegWrite = 0; memWbRegWrite = 0; idExMemRead = 0; exExcept = 0;
  endtask

  // Drive a fresh pattern mid-cycle, then let it settle.
  task automatic nextCycle();
    @(negedge clk);
    clearIn();
  endtask

  task automatic tReset();
    nextCycle(); #1;
    chk("R11", "fwdA", {3'b0, fwdA}, 5'b00000);
    chk("R11", "fwdB", {3'b0, fwdB}, 5'b00000);
    chk("R11", "strobes", ctl(), RUN);
  endtask

  task automatic tForward();
    // R2/R3: near feeds A, far feeds B.
    nextCycle();
    idExRs1 = 9; idExRs2 = 10;
    exMemRd = 9; exMemRegWrite = 1; memWbRd = 10; memWbRegWrite = 1; #1;
    chk("R2", "fwdA near", {3'b0, fwdA}, 5'b00001);
    chk("R3", "fwdB far", {3'b0, fwdB}, 5'b00010);
    // R1: no matching writer.
    nextCycle();
    idExRs1 = 3; idExRs2 = 4;
    exMemRd = 9; exMemRegWrite = 1; memWbRd = 10; memWbRegWrite = 1; #1;
    chk("R1", "fwdA none", {3'b0, fwdA}, 5'b00000);
    chk("R1", "fwdB none", {3'b0, fwdB}, 5'b00000);
    // R3: only the far writer on A.
    nextCycle();
    idExRs1 = 12; idExRs2 = 2; memWbRd = 12; memWbRegWrite = 1; #1;
    chk("R3", "fwdA far only", {3'b0, fwdA}, 5'b00010);
    chk("R1", "fwdB untouched", {3'b0, fwdB}, 5'b00000);
  endtask

  task automatic tPriority();
    nextCycle();
    idExRs1 = 9; idExRs2 = 9;
    exMemRd = 9; exMemRegWrite = 1; memWbRd = 9; memWbRegWrite = 1; #1;
    chk("R4", "fwdA both", {3'b0, fwdA}, 5'b00001);
    chk("R4", "fwdB both", {3'b0, fwdB}, 5'b00001);
    // Near writer inactive: the far one takes over.
    exMemRegWrite = 0; #1;
    chk("R4", "fwdA near off", {3'b0, fwdA}, 5'b00010);
  endtask

  task automatic tSuppress();
    nextCycle();
    idExRs1 = 0; idExRs2 = 0;
    exMemRd = 0; exMemRegWrite = 1; memWbRd = 0; memWbRegWrite = 1; #1;
    chk("R5", "fwdA reg0", {3'b0, fwdA}, 5'b00000);
    chk("R5", "fwdB reg0", {3'b0, fwdB}, 5'b00000);
    nextCycle();
    idExRs1 = 7; idExRs2 = 7; exMemRd = 7; memWbRd = 7; #1;
    chk("R5", "fwdA no write", {3'b0, fwdA}, 5'b00000);
    chk("R5", "fwdB no write", {3'b0, fwdB}, 5'b00000);
  endtask

  task automatic tLoadUse();
    nextCycle();
    idExMemRead = 1; idExRd = 8; ifIdRs1 = 8; ifIdRs2 = 3; #1;
    chk("R6", "stall on rs1", ctl(), HOLD);
    nextCycle(); #1;
    chk("R7", "clean after", ctl(), RUN);
    nextCycle();
    idExMemRead = 1; idExRd = 5; ifIdRs1 = 1; ifIdRs2 = 5; #1;
    chk("R6", "stall on rs2", ctl(), HOLD);
    nextCycle();
    idExMemRead = 0; idExRd = 5; ifIdRs1 = 5; #1;
    chk("R7", "non-load match", ctl(), RUN);
    nextCycle();
    idExMemRead = 1; idExRd = 6; ifIdRs1 = 1; ifIdRs2 = 2; #1;
    chk("R7", "load no match", ctl(), RUN);
  endtask

  task automatic tOneStall();
    nextCycle();
    idExMemRead = 1; idExRd = 11; ifIdRs1 = 11; #1;
    chk("R10", "first hold", ctl(), HOLD);
    @(posedge clk); #1;
    chk("R10", "no second hold", ctl(), RUN);
    @(posedge clk); #1;
    chk("R10", "hold again later", ctl(), HOLD);
  endtask

  task automatic tException();
    nextCycle();
    exExcept = 1; #1;
    chk("R8", "exception flush", ctl(), FLUSH);
    nextCycle();
    exExcept = 1; idExMemRead = 1; idExRd = 4; ifIdRs2 = 4; #1;
    chk("R9", "exception beats stall", ctl(), FLUSH);
    nextCycle(); #1;
    chk("R7", "clean after exception", ctl(), RUN);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tForward();
    tPriority();
    tSuppress();
    tLoadUse();
    tOneStall();
    tException();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule